// File: doc/BRIEF.md
# Motor Drive PWM Generator

This block drives a set of motor-drive outputs from one shared time base. The counter runs either as a saw-tooth (edge-aligned) or as a triangle (center-aligned), and each channel compares it against its own duty value. Duty can span the whole range: an output that never turns on, one that never turns off, and everything in between. Software writes period and duty into holding registers. These values reach the comparators only at a reload event, and only if software has armed the transfer.

Reload events occur at a programmable interval. Each event sets a sticky interrupt flag and gives a one-clock strobe that another timer can use to start conversions. A fault input, when enabled, forces every output to its inactive level. A per-channel current-limit input cuts the running pulse short and holds the output off until the next cycle begins. A one-way lock bit freezes the mode, polarity and fault-enable settings until reset.

The time base is a three-state machine. In TB_IDLE the counter is held at zero; setting run takes it to TB_UP. In TB_UP the counter counts upward. In edge mode it wraps to zero after period-1. In center mode, on reaching the period (non-zero), it takes the peak transition to TB_DOWN. In TB_DOWN the counter counts down; at one or below it takes the valley transition back to TB_UP at zero. Clearing run returns either counting state to TB_IDLE.

Top module: `mcpwm_top`

## Requirements
- R1: Edge mode (CTRL bit 1 = 0): the cycle is P clocks, where P is the period at address 2. Channel i is active for D clocks per cycle, where D is the duty at address 3+i. The output is always active when D >= P and never active when D = 0.
- R2: Center mode (CTRL bit 1 = 1): the cycle is 2P clocks. A channel is active for 2D-1 clocks per cycle when 1 <= D <= P, always active when D > P, and never active when D = 0.
- R3: Writes to period and duty change nothing until a reload event that finds the load-arm flag set (write 1 to CTRL bit 8). The flag clears itself after that transfer, so later writes again wait for a new arm.
- R4: The reload interval field is CTRL bits 7:4, value N. In edge mode a reload occurs every N+1 cycles. In center mode, N = 0 reloads at every peak and every valley, and N >= 1 reloads every N+1 cycles.
- R5: `reload_sync` is high for exactly one clock per reload event.
- R6: `reload_irq` is set by every reload event. It stays set until software writes 1 to CTRL bit 9, and a reload in the same clock wins over the clear.
- R7: When the fault enable (CTRL bit 2) and `fault_in` are both high, every output goes to its inactive level from the next clock.
- R8: A high `ilim_in[i]` turns channel i off from the next clock. The channel stays off for the rest of the cycle and resumes at the next cycle start (counter at zero, counting up).
- R9: Writing 1 to CTRL bit 3 sets the lock. Once locked, the mode bit, the fault enable and the polarity register ignore writes, and the lock itself cannot be cleared until reset.
- R10: Polarity register (address 1) bit i = 1 makes channel i active-low, so its inactive level is 1.
- R11: After reset, all outputs are 0, `reload_irq` and `reload_sync` are 0, and the counter is idle.
- R12: With run (CTRL bit 0) cleared, the counter is idle and all outputs sit at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address (0 control, 1 polarity, 2 period, 3+i duty of channel i) |
| wr_data | input | CW | Register write data |
| fault_in | input | 1 | Fault shutdown request |
| ilim_in | input | NCH | Per-channel current-limit request |
| pwm_out | output | NCH | Channel outputs |
| reload_irq | output | 1 | Sticky reload interrupt flag |
| reload_sync | output | 1 | One-clock strobe at each reload |

## Verification
The bench measures active clocks over whole cycles at the duty extremes, 0, P and above P, in both modes. An off-by-one compare would show up as one clock too many or too few, and a missing clamp would give a glitch at 100%. It times the gap between reload strobes for the half-cycle and multi-cycle intervals, which exposes a reload counter that counts the wrong events. It fires a current-limit pulse early in a cycle and checks that the channel stays dark to the cycle's end and recovers exactly on the next one; a design that fails to latch the limit lights the output again. It also tries to undo a lock, and to change polarity, mode and fault enable once locked; a leaky lock inverts or reshapes the waveform.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
    typedef enum logic [1:0] {TB_IDLE, TB_UP, TB_DOWN} tb_state_e;

    localparam int CB_RUN    = 0;
    localparam int CB_CENTER = 1;
    localparam int CB_FEN    = 2;
    localparam int CB_LOCK   = 3;
    localparam int CB_DIV_LO = 4;
    localparam int CB_LOAD   = 8;
    localparam int CB_ICLR   = 9;

    localparam int A_CTRL  = 0;
    localparam int A_POL   = 1;
    localparam int A_PER   = 2;
    localparam int A_DUTY0 = 3;
endpackage

// File: rtl/mcpwm_regs.sv
module mcpwm_regs
    import mcpwm_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 16,
    parameter int DW  = 4,
    parameter int AW  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [CW-1:0]           wr_data,
    output logic                    run,
    output logic                    center,
    output logic                    fault_en,
    output logic                    lock,
    output logic [DW-1:0]           div,
    output logic [NCH-1:0]          pol,
    output logic [CW-1:0]           per_buf,
    output logic [NCH-1:0][CW-1:0]  duty_buf,
    output logic                    load_set,
    output logic                    irq_clr
);
    logic ctrl_wr;

    always_comb begin
        ctrl_wr  = wr_en && (wr_addr == AW'(A_CTRL));
        load_set = ctrl_wr && wr_data[CB_LOAD];
        irq_clr  = ctrl_wr && wr_data[CB_ICLR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run      <= 1'b0;
            center   <= 1'b0;
            fault_en <= 1'b0;
            lock     <= 1'b0;
            div      <= '0;
            pol      <= '0;
            per_buf  <= '0;
            duty_buf <= '0;
        end else begin
            if (ctrl_wr) begin
                run  <= wr_data[CB_RUN];
                div  <= wr_data[CB_DIV_LO +: DW];
                lock <= lock | wr_data[CB_LOCK];
                if (!lock) begin
                    center   <= wr_data[CB_CENTER];
                    fault_en <= wr_data[CB_FEN];
                end
            end
            if (wr_en && wr_addr == AW'(A_POL) && !lock)
                pol <= wr_data[NCH-1:0];
            if (wr_en && wr_addr == AW'(A_PER))
                per_buf <= wr_data;
            for (int i = 0; i < NCH; i++)
                if (wr_en && wr_addr == AW'(A_DUTY0 + i))
                    duty_buf[i] <= wr_data;
        end
    end

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    // R9
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(center) && $stable(fault_en) && $stable(pol)));
endmodule

// File: rtl/mcpwm_timebase.sv
module mcpwm_timebase
    import mcpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          center,
    input  logic [CW-1:0] per_act,
    output logic [CW-1:0] cnt,
    output logic          idle,
    output logic          valley,
    output logic          peak
);
    tb_state_e     state, nxt;
    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] cnt_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TB_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_inc = cnt + 1'b1;
        cnt_nxt = cnt;
        unique case (state)
            TB_IDLE: begin
                cnt_nxt = '0;
                if (run) nxt = TB_UP;
            end
            TB_UP: begin
                if (!run) begin
                    nxt     = TB_IDLE;
                    cnt_nxt = '0;
                end else if (center) begin
                    if (cnt >= per_act && cnt != '0) begin
                        nxt     = TB_DOWN;
                        cnt_nxt = cnt - 1'b1;
                    end else begin
                        cnt_nxt = cnt_inc;
                    end
                end else begin
                    cnt_nxt = (cnt_inc >= per_act) ? '0 : cnt_inc;
                end
            end
            TB_DOWN: begin
                if (!run) begin
                    nxt     = TB_IDLE;
                    cnt_nxt = '0;
                end else if (cnt <= CW'(1)) begin
                    nxt     = TB_UP;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            default: begin
                nxt     = TB_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    always_comb begin
        idle   = (state == TB_IDLE);
        valley = (state == TB_UP) && (cnt == '0);
        peak   = center && (state == TB_UP) && (cnt != '0) && (cnt >= per_act);
    end
endmodule

// File: rtl/mcpwm_reload.sv
module mcpwm_reload #(
    parameter int NCH = 3,
    parameter int CW  = 16,
    parameter int DW  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    idle,
    input  logic                    valley,
    input  logic                    peak,
    input  logic                    center,
    input  logic [DW-1:0]           div,
    input  logic                    load_set,
    input  logic                    irq_clr,
    input  logic [CW-1:0]           per_buf,
    input  logic [NCH-1:0][CW-1:0]  duty_buf,
    output logic [CW-1:0]           per_act,
    output logic [NCH-1:0][CW-1:0]  duty_act,
    output logic                    reload_irq,
    output logic                    reload_sync
);
    logic [DW-1:0] rcnt;
    logic          fire;
    logic          load_ok;

    always_comb begin
        if (center && div == '0) fire = valley || peak;
        else                     fire = valley && (rcnt >= div);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcnt        <= '0;
            load_ok     <= 1'b0;
            reload_irq  <= 1'b0;
            reload_sync <= 1'b0;
            per_act     <= '0;
            duty_act    <= '0;
        end else begin
            if (idle)        rcnt <= div;
            else if (valley) rcnt <= (rcnt >= div) ? '0 : rcnt + 1'b1;
            reload_sync <= fire;
            if (fire)         reload_irq <= 1'b1;
            else if (irq_clr) reload_irq <= 1'b0;
            if (fire && load_ok) begin
                per_act  <= per_buf;
                duty_act <= duty_buf;
            end
            if (load_set)  load_ok <= 1'b1;
            else if (fire) load_ok <= 1'b0;
        end
    end

    // R3
    load_ok_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && load_ok && !load_set) |=> !load_ok);

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_irq && !irq_clr) |=> reload_irq);
endmodule

// File: rtl/mcpwm_channel.sv
module mcpwm_channel #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] duty,
    input  logic          pol,
    input  logic          fault,
    input  logic          ilim,
    input  logic          valley,
    output logic          pwm
);
    logic lim_q;
    logic drive;

    always_comb
        drive = running && (cnt < duty) && !fault && !ilim && !(lim_q && !valley);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= 1'b0;
            pwm   <= 1'b0;
        end else begin
            lim_q <= valley ? ilim : (lim_q | ilim);
            pwm   <= drive ^ pol;
        end
    end

    // R7
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (pwm == $past(pol)));

    // R8
    limit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_q && !valley) |=> (pwm == $past(pol)));
endmodule

// File: rtl/mcpwm_top.sv
module mcpwm_top #(
    parameter int NCH = 3,
    parameter int CW  = 16,
    parameter int DW  = 4,
    localparam int AW = $clog2(NCH + 3)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    input  logic           fault_in,
    input  logic [NCH-1:0] ilim_in,
    output logic [NCH-1:0] pwm_out,
    output logic           reload_irq,
    output logic           reload_sync
);
    logic                   run, center, fault_en, lock;
    logic [DW-1:0]          div;
    logic [NCH-1:0]         pol;
    logic [CW-1:0]          per_buf, per_act, cnt;
    logic [NCH-1:0][CW-1:0] duty_buf, duty_act;
    logic                   load_set, irq_clr;
    logic                   idle, valley, peak, fault;

    assign fault = fault_en && fault_in;

    mcpwm_regs #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .run(run), .center(center), .fault_en(fault_en), .lock(lock), .div(div),
        .pol(pol), .per_buf(per_buf), .duty_buf(duty_buf),
        .load_set(load_set), .irq_clr(irq_clr)
    );

    mcpwm_timebase #(.CW(CW)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(run), .center(center), .per_act(per_act),
        .cnt(cnt), .idle(idle), .valley(valley), .peak(peak)
    );

    mcpwm_reload #(.NCH(NCH), .CW(CW), .DW(DW)) u_rl (
        .clk(clk), .rst_n(rst_n), .idle(idle), .valley(valley), .peak(peak),
        .center(center), .div(div), .load_set(load_set), .irq_clr(irq_clr),
        .per_buf(per_buf), .duty_buf(duty_buf), .per_act(per_act), .duty_act(duty_act),
        .reload_irq(reload_irq), .reload_sync(reload_sync)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        mcpwm_channel #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .running(!idle), .cnt(cnt), .duty(duty_act[g]),
            .pol(pol[g]), .fault(fault), .ilim(ilim_in[g]), .valley(valley),
            .pwm(pwm_out[g])
        );
    end
endmodule

// File: tb/tb_mcpwm_top.sv
`timescale 1ns/1ps
module tb_mcpwm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        fault_in = 1'b0;
    logic [2:0]  ilim_in = '0;
    logic [2:0]  pwm_out;
    logic        reload_irq, reload_sync;
    int          nrun = 0, nfail = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    mcpwm_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fault_in(fault_in), .ilim_in(ilim_in), .pwm_out(pwm_out),
        .reload_irq(reload_irq), .reload_sync(reload_sync)
    );

    function automatic logic [15:0] mk_ctrl(bit run, bit ctr, bit fen, bit lck,
                                            int dv, bit ld, bit iclr);
        return {6'b0, iclr, ld, 4'(dv), lck, fen, ctr, run};
    endfunction

    task automatic check(string req, int act, int exp);
        nrun++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; fault_in = 1'b0; ilim_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic count_high(int ch, int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out[ch]) c++;
        end
    endtask

    task automatic wait_sync();
        do @(negedge clk); while (!reload_sync);
    endtask

    task automatic sync_gap(output int g);
        wait_sync();
        g = 0;
        do begin @(negedge clk); g++; end while (!reload_sync);
    endtask

    task automatic setup(int per, int d0, int d1, int d2, int pl,
                         bit ctr, bit fen, bit lck, int dv);
        do_reset();
        wr(1, 16'(pl)); wr(2, 16'(per));
        wr(3, 16'(d0)); wr(4, 16'(d1)); wr(5, 16'(d2));
        wr(0, mk_ctrl(1, ctr, fen, lck, dv, 1, 0));
        repeat (4 * per * (dv + 1) + 20) @(negedge clk);
    endtask

    task automatic t_reset();
        int c;
        do_reset();
        check("R11 out", int'(pwm_out), 0);
        check("R11 irq", int'(reload_irq), 0);
        check("R11 sync", int'(reload_sync), 0);
        wr(3, 16'd5);
        count_high(0, 20, c);
        check("R12 idle after reset", c, 0);
    endtask

    task automatic t_edge();
        int c;
        setup(12, 5, 0, 12, 0, 0, 0, 0, 0);
        count_high(0, 12, c); check("R1 duty 5", c, 5);
        count_high(1, 12, c); check("R1 duty 0", c, 0);
        count_high(2, 12, c); check("R1 duty=period", c, 12);
    endtask

    task automatic t_center();
        int c;
        setup(8, 3, 0, 9, 0, 1, 0, 0, 0);
        count_high(0, 16, c); check("R2 duty 3", c, 5);
        count_high(1, 16, c); check("R2 duty 0", c, 0);
        count_high(2, 16, c); check("R2 duty>period", c, 16);
        wr(5, 16'd8); wr(0, mk_ctrl(1, 1, 0, 0, 0, 1, 0));
        repeat (40) @(negedge clk);
        count_high(2, 16, c); check("R2 duty=period", c, 15);
    endtask

    task automatic t_buffer();
        int c;
        setup(10, 4, 0, 0, 0, 0, 0, 0, 0);
        wr(3, 16'd7);
        repeat (30) @(negedge clk);
        count_high(0, 10, c); check("R3 unarmed write held", c, 4);
        wr(0, mk_ctrl(1, 0, 0, 0, 0, 1, 0));
        repeat (30) @(negedge clk);
        count_high(0, 10, c); check("R3 armed write applied", c, 7);
        wr(3, 16'd2);
        repeat (30) @(negedge clk);
        count_high(0, 10, c); check("R3 arm self-clears", c, 7);
    endtask

    task automatic t_interval();
        int g;
        setup(10, 3, 0, 0, 0, 0, 0, 0, 3);
        sync_gap(g); check("R4 edge N=3", g, 40);
        setup(10, 3, 0, 0, 0, 1, 0, 0, 0);
        sync_gap(g); check("R4 center N=0 half cycle", g, 10);
        @(negedge clk);
        check("R5 sync one clock", int'(reload_sync), 0);
        setup(10, 3, 0, 0, 0, 1, 0, 0, 1);
        sync_gap(g); check("R4 center N=1", g, 40);
    endtask

    task automatic t_irq();
        setup(50, 3, 0, 0, 0, 0, 0, 0, 0);
        check("R6 irq set", int'(reload_irq), 1);
        wait_sync();
        wr(0, mk_ctrl(1, 0, 0, 0, 0, 0, 1));
        check("R6 irq cleared", int'(reload_irq), 0);
        wait_sync();
        check("R6 irq set again", int'(reload_irq), 1);
    endtask

    task automatic t_fault();
        int c;
        setup(10, 5, 5, 5, 3'b100, 0, 1, 0, 0);
        fault_in = 1'b1;
        repeat (2) @(negedge clk);
        count_high(0, 10, c); check("R7 fault ch0 off", c, 0);
        count_high(2, 10, c); check("R7 R10 fault ch2 at high idle", c, 10);
        fault_in = 1'b0;
        repeat (2) @(negedge clk);
        count_high(0, 10, c); check("R7 fault released", c, 5);
    endtask

    task automatic t_limit();
        int c;
        setup(20, 10, 0, 0, 0, 0, 0, 0, 0);
        wait_sync();
        ilim_in[0] = 1'b1;
        @(negedge clk);
        ilim_in[0] = 1'b0;
        count_high(0, 18, c); check("R8 off rest of cycle", c, 0);
        count_high(0, 20, c); check("R8 resumes next cycle", c, 10);
    endtask

    task automatic t_pol();
        int c;
        setup(10, 0, 3, 10, 3'b111, 0, 0, 0, 0);
        count_high(0, 10, c); check("R10 duty 0 active-low", c, 10);
        count_high(1, 10, c); check("R10 duty 3 active-low", c, 7);
        count_high(2, 10, c); check("R10 full active-low", c, 0);
    endtask

    task automatic t_lock();
        int c;
        setup(10, 3, 0, 0, 0, 0, 0, 1, 0);
        wr(1, 16'h7);
        wr(0, mk_ctrl(1, 1, 1, 0, 0, 0, 0));
        repeat (30) @(negedge clk);
        count_high(0, 20, c); check("R9 mode and polarity frozen", c, 6);
        fault_in = 1'b1;
        repeat (2) @(negedge clk);
        count_high(0, 20, c); check("R9 fault enable frozen", c, 6);
        fault_in = 1'b0;
    endtask

    task automatic t_stop();
        int c;
        setup(10, 5, 0, 0, 0, 0, 0, 0, 0);
        wr(0, mk_ctrl(0, 0, 0, 0, 0, 0, 0));
        repeat (3) @(negedge clk);
        count_high(0, 20, c); check("R12 stopped", c, 0);
    endtask

    initial begin
        t_reset();
        t_edge();
        t_center();
        t_buffer();
        t_interval();
        t_irq();
        t_fault();
        t_limit();
        t_pol();
        t_lock();
        t_stop();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", nrun, nfail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            nrun++; nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", nrun, nfail);
            $finish;
        end
    end
endmodule